// File: doc/BRIEF.md
# Sampling Converter Serial Port (Device Side)

This block models the digital serial port of an eight-channel sampling converter as the device sees it. A host lowers chip select, toggles a serial clock that idles high, and shifts a 16-bit command word in on the data input. On the same clocks the block shifts out a 16-bit result word. That word carries a 3-bit channel tag, a sign bit and a 12-bit magnitude. A parallel sample port stands in for the analog core, and the block latches it when the frame opens. The block also drives a hold/track indication for the sampling stage.

The first three bits of the command word pick the target: a write flag, then a 2-bit register select. The write is committed part-way through the frame, at a clock edge that depends on the target. The 12-bit control register commits later in the frame than the three 8-bit auxiliary registers (range A, range B, sequence). When chip select rises early, the frame is cut short. A commit that has already happened stays, and one that has not is dropped.

Chip select, serial clock and serial data are sampled on the system clock `clk`. Each serial clock level must therefore last at least one system clock. An edge is acted on in the system clock cycle in which it is first seen, and outputs change at that rising `clk` edge.

Top module: `adc_sp_slave`

## Requirements
- R1: After reset, `sdo_oe`, `hold` and `sdo` are 0, and the control, range A, range B and sequence registers are all 0.
- R2: A falling edge of `cs_n` sets `sdo_oe` and `hold` to 1. It places the top channel-tag bit on `sdo` before any serial clock edge.
- R3: The output word, MSB first, is {ctrl[11:9], sign, magnitude[11:0]}. The control value and the sample port are captured at the `cs_n` falling edge, so later changes to the sample port have no effect on the word. The bit after the top bit appears at the 1st `sclk` falling edge, and each later bit at each following falling edge.
- R4: `hold` stays 1 through the 13th `sclk` rising edge of a frame and drops to 0 at the 14th.
- R5: `sdo_oe` drops to 0 at the 16th `sclk` falling edge. Further `sclk` edges while `cs_n` stays low neither re-enable the output nor change any register.
- R6: `sdi` is sampled on `sclk` falling edges. Input bit 15 (first) is the write flag and bits 14:13 are the select: 00 control, 01 range A, 10 range B, 11 sequence. A frame with write flag 0 changes no register.
- R7: A control write loads input bits 12:1 into the control register at the 15th `sclk` falling edge.
- R8: A range A, range B or sequence write loads input bits 12:5 into that register at the 11th `sclk` falling edge.
- R9: A `cs_n` rise before the 16th falling edge ends the frame: `sdo_oe` and `hold` go to 0 at once. A register commits only if its load edge came in an earlier cycle. A falling edge seen in the same cycle as the rise is discarded.
- R10: `sclk` edges while `cs_n` is high have no effect on outputs or registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial command data in |
| smp_sign | input | 1 | Sign of the sample from the analog core |
| smp_mag | input | 12 | Magnitude of the sample from the analog core |
| sdo | output | 1 | Serial result data out (0 while disabled) |
| sdo_oe | output | 1 | Output enable for the tri-state pad driver |
| hold | output | 1 | 1 = hold, 0 = track |
| ctrl_reg | output | 12 | Control register; bits 11:9 are the channel tag |
| rng_a_reg | output | 8 | Range register A |
| rng_b_reg | output | 8 | Range register B |
| seq_reg | output | 8 | Sequence register |

## Verification
An auxiliary register commit and a frame abort can fall in the same cycle: `cs_n` rising in the very system clock cycle that also sees the 11th `sclk` falling edge. The bench provokes this by driving both pins at the same negative `clk` edge during a sequence-register write. It then judges by reading back the sequence register, which must be unchanged, and by checking that `sdo_oe` and `hold` are both low. Separate frames abort one cycle before and one cycle after the load edges of both register classes, which pins down where each commit lands.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  localparam int unsigned ID_BITS   = 3;
  localparam int unsigned RES_BITS  = 12;
  localparam int unsigned CTRL_BITS = 12;
  localparam int unsigned AUX_BITS  = 8;
  localparam int unsigned HDR_BITS  = 3;
  localparam int unsigned FRAME_BITS = ID_BITS + 1 + RES_BITS;
  localparam int unsigned HOLD_RISE  = 14;

  typedef enum logic [1:0] {
    TGT_CTRL = 2'b00,
    TGT_RNGA = 2'b01,
    TGT_RNGB = 2'b10,
    TGT_SEQ  = 2'b11
  } tgt_e;
endpackage

// File: rtl/adc_sp_edge.sv
module adc_sp_edge #(
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= RST_LVL;
    else        lvl_q <= sig_i;
  end

  assign rise_o = sig_i & ~lvl_q;
  assign fall_o = ~sig_i & lvl_q;
endmodule

// File: rtl/adc_sp_frame_ctl.sv
module adc_sp_frame_ctl #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned HOLD_RISE  = 14,
  localparam int unsigned CW = $clog2(FRAME_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          sck_fall,
  input  logic          sck_rise,
  output logic          active_o,
  output logic          hold_o,
  output logic          fall_ev_o,
  output logic [CW-1:0] fall_idx_o
);
  logic          active_q, active_n;
  logic          hold_q, hold_n;
  logic [CW-1:0] fall_cnt_q, fall_cnt_n;
  logic [CW-1:0] rise_cnt_q, rise_cnt_n;
  logic          fall_ev, rise_ev;
  logic [CW-1:0] fall_idx, rise_idx;

  assign fall_ev  = active_q & sck_fall & ~cs_rise & ~cs_fall;
  assign rise_ev  = active_q & sck_rise & ~cs_rise & ~cs_fall;
  assign fall_idx = fall_cnt_q + 1'b1;
  assign rise_idx = rise_cnt_q + 1'b1;

  always_comb begin
    active_n   = active_q;
    hold_n     = hold_q;
    fall_cnt_n = fall_cnt_q;
    rise_cnt_n = rise_cnt_q;
    if (cs_fall) begin
      active_n   = 1'b1;
      hold_n     = 1'b1;
      fall_cnt_n = '0;
      rise_cnt_n = '0;
    end else if (cs_rise) begin
      active_n = 1'b0;
      hold_n   = 1'b0;
    end else begin
      if (fall_ev) begin
        fall_cnt_n = fall_idx;
        if (fall_idx == CW'(FRAME_BITS)) active_n = 1'b0;
      end
      if (rise_ev) begin
        rise_cnt_n = rise_idx;
        if (rise_idx == CW'(HOLD_RISE)) hold_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      hold_q     <= 1'b0;
      fall_cnt_q <= '0;
      rise_cnt_q <= '0;
    end else begin
      active_q   <= active_n;
      hold_q     <= hold_n;
      fall_cnt_q <= fall_cnt_n;
      rise_cnt_q <= rise_cnt_n;
    end
  end

  assign active_o   = active_q;
  assign hold_o     = hold_q;
  assign fall_ev_o  = fall_ev;
  assign fall_idx_o = fall_idx;
endmodule

// File: rtl/adc_sp_regfile.sv
module adc_sp_regfile
  import adc_sp_pkg::*;
#(
  parameter int unsigned CTRL_BITS = 12,
  parameter int unsigned AUX_BITS  = 8,
  parameter int unsigned HDR_BITS  = 3,
  parameter int unsigned CW        = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 fall_ev,
  input  logic [CW-1:0]        fall_idx,
  input  logic                 sdi,
  output logic [CTRL_BITS-1:0] ctrl_o,
  output logic [AUX_BITS-1:0]  rng_a_o,
  output logic [AUX_BITS-1:0]  rng_b_o,
  output logic [AUX_BITS-1:0]  seq_o
);
  localparam int unsigned SIN_BITS  = CTRL_BITS - 1;
  localparam int unsigned CTRL_FALL = HDR_BITS + CTRL_BITS;
  localparam int unsigned AUX_FALL  = HDR_BITS + AUX_BITS;

  logic [SIN_BITS-1:0]  sin_q, sin_n;
  logic [HDR_BITS-1:0]  hdr_q, hdr_n;
  logic [CTRL_BITS-1:0] ctrl_q, ctrl_n;
  logic [AUX_BITS-1:0]  rng_a_q, rng_a_n, rng_b_q, rng_b_n, seq_q, seq_n;
  logic [CTRL_BITS-1:0] ctrl_word;
  logic [AUX_BITS-1:0]  aux_word;
  logic                 wr_en;
  tgt_e                 tgt;

  assign ctrl_word = {sin_q[CTRL_BITS-2:0], sdi};
  assign aux_word  = {sin_q[AUX_BITS-2:0], sdi};
  assign wr_en     = hdr_q[HDR_BITS-1];
  assign tgt       = tgt_e'(hdr_q[1:0]);

  always_comb begin
    sin_n   = sin_q;
    hdr_n   = hdr_q;
    ctrl_n  = ctrl_q;
    rng_a_n = rng_a_q;
    rng_b_n = rng_b_q;
    seq_n   = seq_q;
    if (frame_start) begin
      hdr_n = '0;
    end else if (fall_ev) begin
      sin_n = {sin_q[SIN_BITS-2:0], sdi};
      if (fall_idx == CW'(HDR_BITS)) hdr_n = {sin_q[HDR_BITS-2:0], sdi};
      if (wr_en && fall_idx == CW'(CTRL_FALL) && tgt == TGT_CTRL) ctrl_n = ctrl_word;
      if (wr_en && fall_idx == CW'(AUX_FALL)) begin
        case (tgt)
          TGT_RNGA: rng_a_n = aux_word;
          TGT_RNGB: rng_b_n = aux_word;
          TGT_SEQ:  seq_n   = aux_word;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_q   <= '0;
      hdr_q   <= '0;
      ctrl_q  <= '0;
      rng_a_q <= '0;
      rng_b_q <= '0;
      seq_q   <= '0;
    end else begin
      sin_q   <= sin_n;
      hdr_q   <= hdr_n;
      ctrl_q  <= ctrl_n;
      rng_a_q <= rng_a_n;
      rng_b_q <= rng_b_n;
      seq_q   <= seq_n;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rng_a_o = rng_a_q;
  assign rng_b_o = rng_b_q;
  assign seq_o   = seq_q;
endmodule

// File: rtl/adc_sp_shifter.sv
module adc_sp_shifter #(
  parameter int unsigned ID_BITS  = 3,
  parameter int unsigned RES_BITS = 12,
  localparam int unsigned WORD_BITS = ID_BITS + 1 + RES_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                shift,
  input  logic                drive,
  input  logic [ID_BITS-1:0]  chan_id,
  input  logic                smp_sign,
  input  logic [RES_BITS-1:0] smp_mag,
  output logic                sdo
);
  logic [WORD_BITS-1:0] word_q, word_n;

  always_comb begin
    word_n = word_q;
    if (load)       word_n = {chan_id, smp_sign, smp_mag};
    else if (shift) word_n = {word_q[WORD_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_n;
  end

  assign sdo = drive & word_q[WORD_BITS-1];
endmodule

// File: rtl/adc_sp_slave.sv
module adc_sp_slave
  import adc_sp_pkg::*;
#(
  parameter int unsigned P_RES_BITS  = RES_BITS,
  parameter int unsigned P_CTRL_BITS = CTRL_BITS,
  parameter int unsigned P_AUX_BITS  = AUX_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  input  logic                   smp_sign,
  input  logic [P_RES_BITS-1:0]  smp_mag,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic                   hold,
  output logic [P_CTRL_BITS-1:0] ctrl_reg,
  output logic [P_AUX_BITS-1:0]  rng_a_reg,
  output logic [P_AUX_BITS-1:0]  rng_b_reg,
  output logic [P_AUX_BITS-1:0]  seq_reg
);
  localparam int unsigned P_FRAME = ID_BITS + 1 + P_RES_BITS;
  localparam int unsigned CW      = $clog2(P_FRAME + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          cs_rise, cs_fall, sck_rise, sck_fall;
  logic          active, fall_ev;
  logic [CW-1:0] fall_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  adc_sp_edge #(.RST_LVL(1'b1)) cs_edge_i (
    .clk(clk), .rst_n(rst_int_n), .sig_i(cs_n), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  adc_sp_edge #(.RST_LVL(1'b1)) sck_edge_i (
    .clk(clk), .rst_n(rst_int_n), .sig_i(sclk), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  adc_sp_frame_ctl #(.FRAME_BITS(P_FRAME), .HOLD_RISE(HOLD_RISE)) ctl_i (
    .clk(clk), .rst_n(rst_int_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_fall(sck_fall), .sck_rise(sck_rise),
    .active_o(active), .hold_o(hold), .fall_ev_o(fall_ev), .fall_idx_o(fall_idx)
  );

  adc_sp_regfile #(
    .CTRL_BITS(P_CTRL_BITS), .AUX_BITS(P_AUX_BITS), .HDR_BITS(HDR_BITS), .CW(CW)
  ) regs_i (
    .clk(clk), .rst_n(rst_int_n),
    .frame_start(cs_fall), .fall_ev(fall_ev), .fall_idx(fall_idx), .sdi(sdi),
    .ctrl_o(ctrl_reg), .rng_a_o(rng_a_reg), .rng_b_o(rng_b_reg), .seq_o(seq_reg)
  );

  adc_sp_shifter #(.ID_BITS(ID_BITS), .RES_BITS(P_RES_BITS)) shf_i (
    .clk(clk), .rst_n(rst_int_n),
    .load(cs_fall), .shift(fall_ev), .drive(active),
    .chan_id(ctrl_reg[P_CTRL_BITS-1 -: ID_BITS]),
    .smp_sign(smp_sign), .smp_mag(smp_mag), .sdo(sdo)
  );

  assign sdo_oe = active;
endmodule

// File: rtl/adc_sp_slave_chk.sv
module adc_sp_slave_chk #(
  parameter int unsigned CB = 12,
  parameter int unsigned AB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sdo_oe,
  input logic          hold,
  input logic [CB-1:0] ctrl_reg,
  input logic [AB-1:0] rng_a_reg,
  input logic [AB-1:0] rng_b_reg,
  input logic [AB-1:0] seq_reg
);
  // R2
  cs_fall_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> (sdo_oe && hold));

  // R9
  cs_rise_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> (!sdo_oe && !hold));

  // R4
  hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> sdo_oe);

  // R5
  oe_start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> ($past(cs_n, 2) && !$past(cs_n)));

  // R7
  ctrl_write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_reg) |-> ($past(sdo_oe) && !$past(cs_n)));

  // R8
  aux_write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({rng_a_reg, rng_b_reg, seq_reg}) |-> ($past(sdo_oe) && !$past(cs_n)));
endmodule

bind adc_sp_slave adc_sp_slave_chk #(.CB(P_CTRL_BITS), .AB(P_AUX_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe), .hold(hold),
  .ctrl_reg(ctrl_reg), .rng_a_reg(rng_a_reg), .rng_b_reg(rng_b_reg), .seq_reg(seq_reg)
);

// File: tb/adc_sp_slave_tb_top.sv
`timescale 1ns/1ps
module adc_sp_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi, smp_sign;
  logic [11:0] smp_mag;
  logic sdo, sdo_oe, hold;
  logic [11:0] ctrl_reg;
  logic [7:0] rng_a_reg, rng_b_reg, seq_reg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [11:0] m_ctrl;
  logic [7:0]  m_ra, m_rb, m_seq;

  always #2.5 clk = ~clk;

  adc_sp_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .smp_sign(smp_sign), .smp_mag(smp_mag), .sdo(sdo), .sdo_oe(sdo_oe), .hold(hold),
    .ctrl_reg(ctrl_reg), .rng_a_reg(rng_a_reg), .rng_b_reg(rng_b_reg), .seq_reg(seq_reg)
  );

  // {din[15:0], sign, mag[11:0]}
  localparam int NV = 7;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 2'b00, 12'hA01, 1'b0, 1'b1, 12'h5A3},
    {1'b1, 2'b01, 8'hC3, 5'h00, 1'b0, 12'hFFF},
    {1'b1, 2'b10, 8'h3C, 5'h1F, 1'b1, 12'h001},
    {1'b1, 2'b11, 8'h96, 5'h0A, 1'b0, 12'h000},
    {1'b0, 2'b00, 12'hFFF, 1'b1, 1'b1, 12'hABC},
    {1'b1, 2'b00, 12'h6E5, 1'b0, 1'b0, 12'h123},
    {1'b0, 2'b11, 12'hFFF, 1'b1, 1'b1, 12'h800}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic c, input logic s, input logic d);
    @(negedge clk);
    cs_n = c; sclk = s; sdi = d;
    @(posedge clk);
    #1;
  endtask

  task automatic model(input logic [15:0] din, input int falls);
    if (din[15]) begin
      if (din[14:13] == 2'b00 && falls >= 15) m_ctrl = din[12:1];
      if (din[14:13] == 2'b01 && falls >= 11) m_ra = din[12:5];
      if (din[14:13] == 2'b10 && falls >= 11) m_rb = din[12:5];
      if (din[14:13] == 2'b11 && falls >= 11) m_seq = din[12:5];
    end
  endtask

  task automatic regs_chk(input string req);
    chk(req, ctrl_reg, m_ctrl);
    chk(req, rng_a_reg, m_ra);
    chk(req, rng_b_reg, m_rb);
    chk(req, seq_reg, m_seq);
  endtask

  // nf: falls before cs rises; coincide: 11th-style fall shares the cs rise cycle
  task automatic frame(input logic [15:0] din, input logic sg, input logic [11:0] mg,
                       input int nf, input bit coincide, input int extra,
                       output logic [15:0] got);
    got = '0;
    smp_sign = sg; smp_mag = mg;
    tick(1'b0, 1'b1, 1'b0);
    chk("R2 oe", sdo_oe, 1);
    chk("R2 hold", hold, 1);
    got[15] = sdo;
    smp_sign = ~sg; smp_mag = ~mg;   // R3: must not affect the word
    for (int k = 1; k <= nf; k++) begin
      tick(1'b0, 1'b0, din[16-k]);
      if (k <= 15) got[15-k] = sdo;
      if (k == 16) chk("R5 oe off at 16th fall", sdo_oe, 0);
      tick(1'b0, 1'b1, din[16-k]);
      if (k == 13) chk("R4 hold at 13th rise", hold, 1);
      if (k == 14) chk("R4 track at 14th rise", hold, 0);
    end
    for (int e = 0; e < extra; e++) begin
      tick(1'b0, 1'b0, 1'b1);
      tick(1'b0, 1'b1, 1'b1);
      chk("R5 oe stays off", sdo_oe, 0);
    end
    if (coincide) tick(1'b1, 1'b0, din[15-nf]);
    else          tick(1'b1, 1'b1, 1'b0);
    chk("R9 oe off", sdo_oe, 0);
    chk("R9 hold off", hold, 0);
    chk("R9 sdo low", sdo, 0);
    tick(1'b1, 1'b1, 1'b0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] got;
    logic [15:0] din;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
    smp_sign = 1'b0; smp_mag = '0;
    m_ctrl = '0; m_ra = '0; m_rb = '0; m_seq = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 oe", sdo_oe, 0);
    chk("R1 hold", hold, 0);
    chk("R1 sdo", sdo, 0);
    regs_chk("R1 regs");

    // Table walk: full frames, word order and register loads (R3, R6, R7, R8)
    for (int i = 0; i < NV; i++) begin
      logic [15:0] exp;
      din = VEC[i][28:13];
      exp = {m_ctrl[11:9], VEC[i][12], VEC[i][11:0]};
      frame(din, VEC[i][12], VEC[i][11:0], 16, 1'b0, 0, got);
      chk("R3 word", got, exp);
      model(din, 16);
      regs_chk("R6 R7 R8 regs");
    end

    // R9: aux write aborted one fall before its load edge
    din = {1'b1, 2'b01, 8'h5A, 5'h00};
    frame(din, 1'b0, 12'h0, 10, 1'b0, 0, got);
    model(din, 10);
    regs_chk("R9 abort before aux load");

    // R8 R9: aux write aborted right after its load edge
    din = {1'b1, 2'b10, 8'hE7, 5'h00};
    frame(din, 1'b0, 12'h0, 11, 1'b0, 0, got);
    model(din, 11);
    regs_chk("R8 R9 abort after aux load");

    // R7 R9: control write aborted at fall 14, then at fall 15
    din = {1'b1, 2'b00, 12'h2B4, 1'b0};
    frame(din, 1'b0, 12'h0, 14, 1'b0, 0, got);
    model(din, 14);
    regs_chk("R7 R9 abort before ctrl load");
    frame(din, 1'b1, 12'h0, 15, 1'b0, 0, got);
    model(din, 15);
    regs_chk("R7 R9 abort after ctrl load");

    // R9: cs rise in the same cycle as the 11th fall, sequence write dropped
    din = {1'b1, 2'b11, 8'h41, 5'h00};
    frame(din, 1'b0, 12'h0, 10, 1'b1, 0, got);
    model(din, 10);
    regs_chk("R9 coincident abort");

    // R5: extra clocks after the 16th fall with cs low
    din = {1'b1, 2'b01, 8'h77, 5'h00};
    frame(din, 1'b0, 12'hFFF, 16, 1'b0, 3, got);
    model(din, 16);
    regs_chk("R5 extra clocks");

    // R10: serial clock toggling with chip select high
    for (int k = 0; k < 20; k++) begin
      tick(1'b1, 1'b0, 1'b1);
      tick(1'b1, 1'b1, 1'b1);
    end
    chk("R10 oe", sdo_oe, 0);
    chk("R10 hold", hold, 0);
    regs_chk("R10 regs");

    // R3: word after the writes above uses the newest channel tag
    frame({1'b0, 15'h0}, 1'b1, 12'h3C5, 16, 1'b0, 0, got);
    chk("R3 tag after update", got, {m_ctrl[11:9], 1'b1, 12'h3C5});

    // R1: second reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    m_ctrl = '0; m_ra = '0; m_rb = '0; m_seq = '0;
    #1;
    chk("R1 oe after reset", sdo_oe, 0);
    regs_chk("R1 regs after reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule